// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects five hardware interrupt requests for a small processor core and decides which one, if any, the core should service next. One request is non-maskable. Three vectored requests can each be switched off by a mask bit. The fifth is a general request that carries no fixed vector. A global enable flag gates every source except the non-maskable one. The core sets and clears this flag with one-cycle enable and disable commands. Servicing any interrupt clears the flag again.

The core reconfigures the block with a one-cycle write command carrying a byte from its accumulator. That byte can load new mask bits, cancel a captured edge on the highest vectored input, and drive a serial output pin. A status byte is always present on an output port. It packs the masks, the enable flag, the pending vectored requests and the level of the serial input pin, so the core can read it back at any time.

The controller shows the current winner as a one-hot source code and as a vector address. When the core pulses the accept input while a request is present, the block takes the acceptance side effects on the next clock edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all three mask bits are 1, the enable flag is 0, `ser_out` is 0 and both edge captures are empty. With all inputs low, `status` reads 8'h07 and `irq` is 0.
- R2: `win_src` is one-hot or zero, and `irq` is 1 exactly when it is nonzero. The bits of `win_src` are: bit 0 non-maskable, bit 1 high vectored, bit 2 middle vectored, bit 3 low vectored, bit 4 general. Priority runs from bit 0 (highest) to bit 4 (lowest). The vectors are 16'h0024, 16'h003C, 16'h0034 and 16'h002C for bits 0 to 3.
- R3: The non-maskable request becomes eligible on a rising edge of `req_nmi`. It stays eligible only while `req_nmi` remains high. A falling level withdraws it. The enable flag and the masks never affect it.
- R4: `cmd_ie_set` sets the enable flag and `cmd_ie_clr` clears it. An acceptance in the same cycle overrides both, and a clear overrides a set.
- R5: A write (`cmd_wr`) loads `cmd_wdata[2:0]` into the masks only when `cmd_wdata[3]` is 1. Bit 0 masks the low vectored input, bit 1 the middle one and bit 2 the high one. A mask bit of 1 disables its input.
- R6: An unmasked vectored request or a general request can win only while the enable flag is 1.
- R7: The high vectored input is captured on a rising edge of `req_v3` and stays pending after the input falls. It is cleared by its own acceptance or by a write with `cmd_wdata[4]` = 1. A clear overrides a coincident edge.
- R8: A write with `cmd_wdata[6]` = 1 copies `cmd_wdata[7]` to `ser_out`. Any other write leaves `ser_out` unchanged.
- R9: `status` is {`ser_in`, high-input capture, `req_v2`, `req_v1`, enable flag, masks[2:0]}, with bit 7 on the left.
- R10: An acceptance (`take` = 1 while `irq` = 1) clears the enable flag. It also empties the capture of the non-maskable or high vectored source when that source won.
- R11: The general request is level-sensitive, has the lowest priority and reports vector 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_nmi | input | 1 | Non-maskable request, edge-detected and level-held |
| req_v3 | input | 1 | High vectored request, edge-captured |
| req_v2 | input | 1 | Middle vectored request, level-sensitive |
| req_v1 | input | 1 | Low vectored request, level-sensitive |
| req_gen | input | 1 | General request, level-sensitive, no fixed vector |
| cmd_ie_set | input | 1 | Enable command pulse |
| cmd_ie_clr | input | 1 | Disable command pulse |
| cmd_wr | input | 1 | Mask/serial write command pulse |
| cmd_wdata | input | 8 | Write value |
| ser_in | input | 1 | Serial input pin, reported in status bit 7 |
| take | input | 1 | Core accepts the current winner |
| irq | output | 1 | A request is eligible |
| win_src | output | 5 | One-hot winning source |
| win_vec | output | 16 | Vector address of the winner |
| status | output | 8 | Read-back status byte |
| ser_out | output | 1 | Serial output pin |

## Verification
The bench targets collisions between events in the same cycle. These include a capture clear landing with a new edge on the high input, an acceptance arriving alongside an enable or disable command, and a write that sets the reset-capture bit without the mask-load bit. A design with the wrong precedence would leave a stale pending bit or re-enable interrupts right after an acceptance. Other targets are a non-maskable request whose level drops before service, and a second rise of a held line. A wrong design would service a withdrawn request, or re-service a held one without a fresh edge. Writes that lack the mask-load or serial-enable bit are also checked, since a design that ignores those gates would silently change masks or the output pin.

// File: rtl/irq_prio_pkg.sv
// Shared constants and helpers for the interrupt controller.
// Assumes source index order equals priority order (0 = highest).
package irq_prio_pkg;

    localparam int SRC_N  = 5;
    localparam int MASK_N = 3;

    typedef enum int unsigned {
        SRC_NMI = 0,
        SRC_V3  = 1,
        SRC_V2  = 2,
        SRC_V1  = 3,
        SRC_GEN = 4
    } src_e;

    // Vector address of a source: 8*slot+4, no fixed vector for the general input.
    function automatic logic [31:0] src_vector(input int idx);
        int slot;
        case (idx)
            SRC_NMI: slot = 4;
            SRC_V3:  slot = 7;
            SRC_V2:  slot = 6;
            SRC_V1:  slot = 5;
            default: slot = -1;
        endcase
        if (slot < 0) return 32'd0;
        return 32'(8 * slot + 4);
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
// Rising-edge capture of one request line.
// HOLD_LEVEL=0: capture persists until clr. HOLD_LEVEL=1: capture also
// drops when the line falls, and the output needs the line still high.
// Assumes lvl is already synchronous to clk.
module irq_edge_latch #(
    parameter bit HOLD_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic clr,
    output logic cap,
    output logic pend
);

    logic prev_q;
    logic cap_q;
    logic rise;

    assign rise = lvl & ~prev_q;

    // Track the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Capture register: clear wins over a new edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cap_q <= 1'b0;
        else if (clr)                   cap_q <= 1'b0;
        else if (rise)                  cap_q <= 1'b1;
        else if (HOLD_LEVEL && !lvl)    cap_q <= 1'b0;
    end

    assign cap  = cap_q;
    assign pend = HOLD_LEVEL ? (cap_q & lvl) : cap_q;

    // R7 / R3: an uncleared edge is captured on the next cycle.
    p_edge_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl && !prev_q && !clr) |=> cap_q);

    // R7: an uncleared capture persists (while the line is held, when required).
    p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q && !clr && (lvl || !HOLD_LEVEL)) |=> cap_q);

endmodule

// File: rtl/irq_mask_reg.sv
// Holds mask bits, the global enable flag and the serial output pin.
// Assumes command inputs are single-cycle pulses from the core.
module irq_mask_reg #(
    parameter int MASK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              mse,
    input  logic [MASK_W-1:0] mask_val,
    input  logic              soe,
    input  logic              sdat,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              accept,
    output logic [MASK_W-1:0] mask,
    output logic              ie,
    output logic              ser_out
);

    logic [MASK_W-1:0] mask_q;
    logic              ie_q;
    logic              so_q;

    // Mask load gated by the mask-set-enable bit; reset masks everything.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '1;
        else if (wr && mse)  mask_q <= mask_val;
    end

    // Enable flag: acceptance, then disable, then enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       ie_q <= 1'b0;
        else if (accept)  ie_q <= 1'b0;
        else if (ie_clr)  ie_q <= 1'b0;
        else if (ie_set)  ie_q <= 1'b1;
    end

    // Serial output updated only by a write with serial enable.
    always_ff @(posedge clk) begin
        if (!rst_n)          so_q <= 1'b0;
        else if (wr && soe)  so_q <= sdat;
    end

    assign mask    = mask_q;
    assign ie      = ie_q;
    assign ser_out = so_q;

    p_mask_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && mse) |=> $stable(mask_q));

    p_ser_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && soe) |=> $stable(so_q));

    p_ie_precedence_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_clr || accept) |=> !ie_q);

endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority selection among eligible sources plus vector lookup.
// Assumes index 0 is the highest priority; clk/rst_n feed checks only.
module irq_arbiter
    import irq_prio_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pend,
    input  logic              v3_pend,
    input  logic              v2_lvl,
    input  logic              v1_lvl,
    input  logic              gen_lvl,
    input  logic [MASK_N-1:0] mask,
    input  logic              ie,
    output logic [SRC_N-1:0]  win,
    output logic [VEC_W-1:0]  vec,
    output logic              any
);

    logic [SRC_N-1:0] elig;

    // Eligibility: non-maskable bypasses enable and masks.
    always_comb begin
        elig          = '0;
        elig[SRC_NMI] = nmi_pend;
        elig[SRC_V3]  = ie & ~mask[2] & v3_pend;
        elig[SRC_V2]  = ie & ~mask[1] & v2_lvl;
        elig[SRC_V1]  = ie & ~mask[0] & v1_lvl;
        elig[SRC_GEN] = ie & gen_lvl;
    end

    for (genvar i = 0; i < SRC_N; i++) begin : g_pri
        if (i == 0) begin : g_top
            assign win[i] = elig[i];
        end else begin : g_rest
            assign win[i] = elig[i] & ~|elig[i-1:0];
        end
    end

    // Vector mux over the one-hot winner.
    always_comb begin
        vec = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (win[i]) vec = vec | src_vector(i)[VEC_W-1:0];
        end
    end

    assign any = |elig;

    p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));

    p_nmi_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |-> win[SRC_NMI]);

    p_gate_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> (win[SRC_GEN:SRC_V3] == '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the prioritized maskable interrupt controller.
// Assumes all request lines and commands are synchronous to clk.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_nmi,
    input  logic              req_v3,
    input  logic              req_v2,
    input  logic              req_v1,
    input  logic              req_gen,
    input  logic              cmd_ie_set,
    input  logic              cmd_ie_clr,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_wdata,
    input  logic              ser_in,
    input  logic              take,
    output logic              irq,
    output logic [SRC_N-1:0]  win_src,
    output logic [VEC_W-1:0]  win_vec,
    output logic [7:0]        status,
    output logic              ser_out
);

    logic [MASK_N-1:0] mask;
    logic              ie;
    logic              any;
    logic              accept;
    logic              nmi_cap, nmi_pend, v3_cap, v3_pend;
    logic              nmi_clr, v3_clr;
    logic              unused_wbit;

    assign unused_wbit = cmd_wdata[5];
    assign accept      = take & any;
    assign nmi_clr     = accept & win_src[SRC_NMI];
    assign v3_clr      = (cmd_wr & cmd_wdata[4]) | (accept & win_src[SRC_V3]);

    irq_edge_latch #(.HOLD_LEVEL(1'b1)) u_nmi (
        .clk(clk), .rst_n(rst_n), .lvl(req_nmi), .clr(nmi_clr),
        .cap(nmi_cap), .pend(nmi_pend)
    );

    irq_edge_latch #(.HOLD_LEVEL(1'b0)) u_v3 (
        .clk(clk), .rst_n(rst_n), .lvl(req_v3), .clr(v3_clr),
        .cap(v3_cap), .pend(v3_pend)
    );

    irq_mask_reg #(.MASK_W(MASK_N)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .mse(cmd_wdata[3]),
        .mask_val(cmd_wdata[MASK_N-1:0]), .soe(cmd_wdata[6]), .sdat(cmd_wdata[7]),
        .ie_set(cmd_ie_set), .ie_clr(cmd_ie_clr), .accept(accept),
        .mask(mask), .ie(ie), .ser_out(ser_out)
    );

    irq_arbiter #(.VEC_W(VEC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .nmi_pend(nmi_pend), .v3_pend(v3_pend),
        .v2_lvl(req_v2), .v1_lvl(req_v1), .gen_lvl(req_gen),
        .mask(mask), .ie(ie), .win(win_src), .vec(win_vec), .any(any)
    );

    assign irq    = any;
    assign status = {ser_in, v3_cap, req_v2, req_v1, ie, mask};

    p_accept_clears_ie_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq) |=> !status[3]);

    p_nmi_accept_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win_src[SRC_NMI]) |=> !nmi_cap);

    p_v3_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[4]) |=> !status[6]);

endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_nmi, req_v3, req_v2, req_v1, req_gen;
    logic        cmd_ie_set, cmd_ie_clr, cmd_wr;
    logic [7:0]  cmd_wdata;
    logic        ser_in, take;
    logic        irq;
    logic [4:0]  win_src;
    logic [15:0] win_vec;
    logic [7:0]  status;
    logic        ser_out;

    always #5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_nmi(req_nmi), .req_v3(req_v3),
        .req_v2(req_v2), .req_v1(req_v1), .req_gen(req_gen),
        .cmd_ie_set(cmd_ie_set), .cmd_ie_clr(cmd_ie_clr), .cmd_wr(cmd_wr),
        .cmd_wdata(cmd_wdata), .ser_in(ser_in), .take(take), .irq(irq),
        .win_src(win_src), .win_vec(win_vec), .status(status), .ser_out(ser_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [2:0] m_mask;
    logic m_ie, m_so, m_l75, m_p75, m_ln, m_pn;

    function automatic logic [4:0] exp_elig();
        logic [4:0] e;
        e[0] = m_ln & req_nmi;
        e[1] = m_ie & ~m_mask[2] & m_l75;
        e[2] = m_ie & ~m_mask[1] & req_v2;
        e[3] = m_ie & ~m_mask[0] & req_v1;
        e[4] = m_ie & req_gen;
        return e;
    endfunction

    function automatic logic [4:0] exp_win();
        logic [4:0] e = exp_elig();
        for (int i = 0; i < 5; i++) if (e[i]) return 5'(1 << i);
        return 5'd0;
    endfunction

    function automatic logic [15:0] exp_vec(input logic [4:0] w);
        case (w)
            5'b00001: return 16'h0024;
            5'b00010: return 16'h003C;
            5'b00100: return 16'h0034;
            5'b01000: return 16'h002C;
            default:  return 16'h0000;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {ser_in, m_l75, req_v2, req_v1, m_ie, m_mask};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cmd_ie_set = 1'b0; cmd_ie_clr = 1'b0; cmd_wr = 1'b0; take = 1'b0;
    endtask

    // Compare outputs, advance the model across the next rising edge.
    task automatic cycle();
        logic [4:0] w;
        logic acc, clr75, rise75, risen;
        #1;
        w = exp_win();
        chk("R2 irq", {31'd0, irq}, {31'd0, |w});
        chk("R2 winner", {27'd0, win_src}, {27'd0, w});
        chk("R2 R11 vector", {16'd0, win_vec}, {16'd0, exp_vec(w)});
        chk("R9 status", {24'd0, status}, {24'd0, exp_status()});
        chk("R8 serial out", {31'd0, ser_out}, {31'd0, m_so});
        acc    = take & (|w);
        rise75 = req_v3 & ~m_p75;
        clr75  = (cmd_wr & cmd_wdata[4]) | (acc & w[1]);
        risen  = req_nmi & ~m_pn;
        if (clr75) m_l75 = 1'b0; else if (rise75) m_l75 = 1'b1;
        if (acc & w[0]) m_ln = 1'b0;
        else if (risen) m_ln = 1'b1;
        else if (!req_nmi) m_ln = 1'b0;
        if (acc) m_ie = 1'b0; else if (cmd_ie_clr) m_ie = 1'b0; else if (cmd_ie_set) m_ie = 1'b1;
        if (cmd_wr && cmd_wdata[3]) m_mask = cmd_wdata[2:0];
        if (cmd_wr && cmd_wdata[6]) m_so = cmd_wdata[7];
        m_p75 = req_v3;
        m_pn  = req_nmi;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        req_nmi = 0; req_v3 = 0; req_v2 = 0; req_v1 = 0; req_gen = 0;
        cmd_wdata = 8'h00; ser_in = 1'b0;
        idle();
        m_mask = 3'b111; m_ie = 0; m_so = 0; m_l75 = 0; m_p75 = 0; m_ln = 0; m_pn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 status", {24'd0, status}, 32'h07);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 ser_out", {31'd0, ser_out}, 32'd0);
        cycle();

        // R3: non-maskable with enable off and all masks set
        req_nmi = 1; cycle();
        #1;
        chk("R3 nmi winner", {27'd0, win_src}, 32'h01);
        chk("R3 nmi vector", {16'd0, win_vec}, 32'h24);
        take = 1; cycle(); idle();
        #1;
        chk("R10 nmi capture emptied", {31'd0, irq}, 32'd0);
        req_nmi = 0; cycle();
        // R3: level drop withdraws the request
        req_nmi = 1; cycle(); req_nmi = 0;
        #1;
        chk("R3 withdrawn on fall", {31'd0, irq}, 32'd0);
        cycle();

        // R4: enable command
        cmd_ie_set = 1; cycle(); idle();
        #1; chk("R4 enable flag", {31'd0, status[3]}, 32'd1);

        // R5: write without mask-set-enable leaves masks
        cmd_wr = 1; cmd_wdata = 8'h00; cycle(); idle();
        #1; chk("R5 masks kept", {29'd0, status[2:0]}, 32'h7);
        cmd_wr = 1; cmd_wdata = 8'h08; cycle(); idle();
        #1; chk("R5 masks loaded", {29'd0, status[2:0]}, 32'h0);

        // R2: middle beats low
        req_v1 = 1; req_v2 = 1;
        #1; chk("R2 middle wins", {16'd0, win_vec}, 32'h34);
        cycle();
        // R7: high vectored edge captured and held
        req_v3 = 1; cycle();
        #1; chk("R7 high wins", {16'd0, win_vec}, 32'h3C);
        req_v3 = 0; cycle();
        #1; chk("R7 capture held", {31'd0, status[6]}, 32'd1);
        cmd_wr = 1; cmd_wdata = 8'h10; cycle(); idle();
        #1; chk("R7 capture cleared", {31'd0, status[6]}, 32'd0);

        // R10 / R6: accept clears enable; unmasked level inputs then blocked
        take = 1; cycle(); idle();
        #1;
        chk("R10 enable cleared", {31'd0, status[3]}, 32'd0);
        chk("R6 blocked without enable", {31'd0, irq}, 32'd0);

        // R11: general request, no vector
        req_v1 = 0; req_v2 = 0; req_gen = 1; cmd_ie_set = 1; cycle(); idle();
        #1;
        chk("R11 general winner", {27'd0, win_src}, 32'h10);
        chk("R11 general vector", {16'd0, win_vec}, 32'h0);

        // R8: serial output gating
        cmd_wr = 1; cmd_wdata = 8'hC0; cycle(); idle();
        #1; chk("R8 ser_out set", {31'd0, ser_out}, 32'd1);
        cmd_wr = 1; cmd_wdata = 8'h00; cycle(); idle();
        #1; chk("R8 ser_out kept", {31'd0, ser_out}, 32'd1);
        cmd_wr = 1; cmd_wdata = 8'h40; cycle(); idle();
        #1; chk("R8 ser_out cleared", {31'd0, ser_out}, 32'd0);

        // R9: serial input reported
        ser_in = 1;
        #1; chk("R9 ser_in bit", {31'd0, status[7]}, 32'd1);
        cycle();

        // R4: disable command blocks general request
        cmd_ie_clr = 1; cycle(); idle();
        #1; chk("R4 disable", {31'd0, irq}, 32'd0);
        cycle();

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 6 == 0) req_nmi = ~req_nmi;
            if ($urandom % 4 == 0) req_v3  = ~req_v3;
            if ($urandom % 5 == 0) req_v2  = ~req_v2;
            if ($urandom % 5 == 0) req_v1  = ~req_v1;
            if ($urandom % 7 == 0) req_gen = ~req_gen;
            cmd_ie_set = ($urandom % 6 == 0);
            cmd_ie_clr = ($urandom % 14 == 0);
            cmd_wr     = ($urandom % 8 == 0);
            cmd_wdata  = 8'($urandom);
            ser_in     = 1'($urandom);
            take       = ($urandom % 3 == 0);
            cycle();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule